// File: doc/BRIEF.md
# Banked Configuration Stream Parser

This block turns a byte-wide configuration stream into write strobes for a configuration memory split into banks. Bytes arrive one at a time with a valid qualifier. The parser throws away filler until it finds the sync value. In the full (primary) stream format it then skips a fixed-length run of identity bytes. After that it checks a device identifier and a control byte, and then walks through a chain of data blocks.

Each block opens with a header byte that carries the start address and a continuation flag. A bank byte and a byte count follow, then the payload, then a fixed closing marker. Every payload byte becomes one write to the selected bank, at consecutive addresses from the start address. A frame that is addressed to another device is dropped without any report. A bad control byte or a missing closing marker aborts the frame with an error pulse. A properly closed last block produces a completion pulse.

Top module: `cfg_stream_parser`

## Requirements
- R1: After synchronous reset, and after a reset applied in the middle of a frame, `wr_en`, `frame_done` and `frame_err` are low and the parser is hunting for sync. Bytes that belonged to the interrupted frame cause no writes.
- R2: While hunting, every byte other than 0xD5 (filler 0x00 included) is ignored and causes no write, no error and no completion.
- R3: With `full_mode`=1, exactly four bytes after sync are skipped whatever their value, 0xD5 included, and the fifth byte is the device ID. With `full_mode`=0, the byte right after sync is the device ID.
- R4: A device-ID byte that differs from `my_id` drops the frame silently, with no write, error or completion, and the parser returns to hunting for sync.
- R5: A control byte other than 0xC1 raises `frame_err` for one cycle, performs no write and returns the parser to hunting.
- R6: In a header byte, bits [4:0] give the start address and bit 6 set means another block follows. The low two bits of the bank byte select `wr_bank`.
- R7: Each payload byte produces exactly one `wr_en` pulse, in the cycle after the byte is accepted, carrying that byte. Addresses climb by one from the start address and wrap from 31 to 0.
- R8: A count byte of 0 gives a block with no writes, and the next byte is taken as the closing marker.
- R9: A block whose closing byte is not 0x2A raises `frame_err` for one cycle and aborts the frame. Writes already issued, including those from earlier blocks of the same frame, still go out.
- R10: A closing 0x2A on a block with bit 6 clear gives a one-cycle `frame_done` pulse in the following cycle. With bit 6 set, the next byte is parsed as a new header.
- R11: Cycles with `byte_valid` low leave the parse unchanged, so gaps of any length between bytes give the same writes and flags.
- R12: `wr_en`, `frame_done` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | `byte_in` holds a stream byte this cycle |
| byte_in | input | 8 | Stream byte |
| full_mode | input | 1 | 1: identity bytes follow sync; 0: short stream |
| my_id | input | 8 | Device identifier this parser answers to |
| wr_en | output | 1 | Write strobe to the configuration memory |
| wr_bank | output | 2 | Bank of the write |
| wr_addr | output | 5 | Byte address within the bank |
| wr_data | output | 8 | Write data |
| frame_done | output | 1 | One-cycle pulse: frame closed correctly |
| frame_err | output | 1 | One-cycle pulse: frame aborted on a bad control byte or closing marker |

## Verification
The bench aims at the places where a parser typically goes wrong. It puts a 0xD5 inside the identity run: a parser that re-syncs there would read the wrong device ID and lose every write. It sends a zero-count block: a parser that enters the payload state would swallow the marker as data and drift out of step. It runs a block across address 31: a wrong wrap would write out of range or miss address 0. It ends a block with a bad marker after a good block, to show that earlier writes stand and that completion is withheld. A foreign-ID frame is followed by a valid one, so a parser that does not re-enter hunting would miss the second frame. A reset in mid-payload and a run with idle gaps between bytes show that stale state and idle cycles do not leak into the parse.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    // Parser phases, in stream order.
    typedef enum logic [3:0] {
        ST_HUNT,
        ST_PREAMBLE,
        ST_DEVID,
        ST_CTRL,
        ST_HDR,
        ST_BANK,
        ST_COUNT,
        ST_DATA,
        ST_ENDM
    } cfgp_state_e;

endpackage

// File: rtl/cfgp_frame_fsm.sv
// cfgp_frame_fsm
// Walks the stream one accepted byte at a time and emits load/write/event
// strobes for the block tracker and the write port.
// Assumes: a byte counts only when byte_valid is high; the block tracker
// reports remain_one/more_flag for the block currently being parsed.
module cfgp_frame_fsm
    import cfgp_pkg::*;
#(
    parameter int          PREAMBLE_LEN = 4,
    parameter logic [7:0]  SYNC_BYTE    = 8'hD5,
    parameter logic [7:0]  CTRL_BYTE    = 8'hC1,
    parameter logic [7:0]  END_BYTE     = 8'h2A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    input  logic       full_mode,
    input  logic [7:0] my_id,
    input  logic       remain_one,
    input  logic       more_flag,
    output logic       ld_hdr,
    output logic       ld_bank,
    output logic       ld_cnt,
    output logic       do_write,
    output logic       done_pulse,
    output logic       err_pulse
);

    localparam bit HAS_PRE = (PREAMBLE_LEN > 0);
    localparam int PRE_W   = (PREAMBLE_LEN > 1) ? $clog2(PREAMBLE_LEN) : 1;

    cfgp_state_e state, nxt;
    logic        pre_last;

    // Identity-byte counter: only built when more than one byte is skipped.
    generate
        if (PREAMBLE_LEN > 1) begin : g_pre_cnt
            logic [PRE_W-1:0] pre_cnt;

            // Counts accepted identity bytes, cleared outside that phase.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (state != ST_PREAMBLE) begin
                    pre_cnt <= '0;
                end else if (byte_valid) begin
                    pre_cnt <= pre_cnt + PRE_W'(1);
                end
            end

            assign pre_last = (pre_cnt == PRE_W'(PREAMBLE_LEN - 1));
        end else begin : g_pre_single
            assign pre_last = 1'b1;
        end
    endgenerate

    // Next-phase decision and strobes for the current accepted byte.
    always_comb begin
        nxt        = state;
        ld_hdr     = 1'b0;
        ld_bank    = 1'b0;
        ld_cnt     = 1'b0;
        do_write   = 1'b0;
        done_pulse = 1'b0;
        err_pulse  = 1'b0;
        if (byte_valid) begin
            unique case (state)
                ST_HUNT: begin
                    if (byte_in == SYNC_BYTE) begin
                        nxt = (full_mode && HAS_PRE) ? ST_PREAMBLE : ST_DEVID;
                    end
                end
                ST_PREAMBLE: begin
                    if (pre_last) nxt = ST_DEVID;
                end
                ST_DEVID: begin
                    nxt = (byte_in == my_id) ? ST_CTRL : ST_HUNT;
                end
                ST_CTRL: begin
                    if (byte_in == CTRL_BYTE) begin
                        nxt = ST_HDR;
                    end else begin
                        err_pulse = 1'b1;
                        nxt       = ST_HUNT;
                    end
                end
                ST_HDR: begin
                    ld_hdr = 1'b1;
                    nxt    = ST_BANK;
                end
                ST_BANK: begin
                    ld_bank = 1'b1;
                    nxt     = ST_COUNT;
                end
                ST_COUNT: begin
                    ld_cnt = 1'b1;
                    nxt    = (byte_in == 8'h00) ? ST_ENDM : ST_DATA;
                end
                ST_DATA: begin
                    do_write = 1'b1;
                    nxt      = remain_one ? ST_ENDM : ST_DATA;
                end
                ST_ENDM: begin
                    if (byte_in != END_BYTE) begin
                        err_pulse = 1'b1;
                        nxt       = ST_HUNT;
                    end else if (more_flag) begin
                        nxt = ST_HDR;
                    end else begin
                        done_pulse = 1'b1;
                        nxt        = ST_HUNT;
                    end
                end
                default: nxt = ST_HUNT;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // R11: an idle input cycle leaves the phase untouched.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> state == $past(state));

    // R4: a foreign device ID sends the parser back to hunting.
    a_r4_foreign_id: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && state == ST_DEVID && byte_in != my_id) |=> state == ST_HUNT);

    // R5/R9: every abort lands in the hunting phase.
    a_r5_abort_hunts: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> state == ST_HUNT);

    // R10: completion only comes from a closing marker on a last block.
    a_r10_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!more_flag && byte_in == END_BYTE));

endmodule

// File: rtl/cfgp_block_ctr.sv
// cfgp_block_ctr
// Holds the per-block context: current bank, running address, continuation
// flag and number of payload bytes still expected.
// Assumes: at most one of ld_hdr/ld_bank/ld_cnt/do_write is high per cycle.
module cfgp_block_ctr #(
    parameter int ADDR_W = 5,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hdr,
    input  logic              ld_bank,
    input  logic              ld_cnt,
    input  logic              do_write,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic              hdr_more,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [7:0]        count_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BANK_W-1:0] cur_bank,
    output logic              more_flag,
    output logic              remain_one
);

    logic [7:0] remain;

    // Address and continuation flag: loaded by a header, stepped per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            more_flag <= 1'b0;
        end else if (ld_hdr) begin
            cur_addr  <= hdr_addr;
            more_flag <= hdr_more;
        end else if (do_write) begin
            cur_addr  <= cur_addr + ADDR_W'(1);
        end
    end

    // Bank selection latched from the bank byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_bank <= '0;
        else if (ld_bank) cur_bank <= bank_sel;
    end

    // Payload bytes still to come in this block.
    always_ff @(posedge clk) begin
        if (!rst_n)        remain <= '0;
        else if (ld_cnt)   remain <= count_in;
        else if (do_write) remain <= remain - 8'd1;
    end

    assign remain_one = (remain == 8'd1);

    // R8: a write is never requested when the block has no bytes left.
    a_r8_write_needs_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |-> remain != 8'd0);

endmodule

// File: rtl/cfgp_write_port.sv
// cfgp_write_port
// Registers the memory write and the frame event pulses so that every
// output of the parser leaves a flop.
// Assumes: do_write, done_pulse and err_pulse come from one accepted byte.
module cfgp_write_port #(
    parameter int ADDR_W = 5,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_write,
    input  logic              done_pulse,
    input  logic              err_pulse,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic [7:0]        data_in,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              frame_done,
    output logic              frame_err
);

    // Write strobe and its payload, one cycle after the byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_bank <= '0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= do_write;
            if (do_write) begin
                wr_bank <= cur_bank;
                wr_addr <= cur_addr;
                wr_data <= data_in;
            end
        end
    end

    // Frame outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            frame_done <= done_pulse;
            frame_err  <= err_pulse;
        end
    end

    // R12: at most one output event per cycle.
    a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, frame_done, frame_err}));

    // R10: completion is a single-cycle pulse.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

// File: rtl/cfg_stream_parser.sv
// cfg_stream_parser
// Top level: parses a framed configuration byte stream into banked memory
// writes with completion and error pulses.
// Assumes: one byte per cycle at most, qualified by byte_valid; the header
// address field fits below the continuation bit.
module cfg_stream_parser #(
    parameter int          ADDR_W       = 5,
    parameter int          BANK_W       = 2,
    parameter int          PREAMBLE_LEN = 4,
    parameter logic [7:0]  SYNC_BYTE    = 8'hD5,
    parameter logic [7:0]  CTRL_BYTE    = 8'hC1,
    parameter logic [7:0]  END_BYTE     = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              full_mode,
    input  logic [7:0]        my_id,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              frame_done,
    output logic              frame_err
);

    localparam int MORE_BIT = 6;

    logic              ld_hdr, ld_bank, ld_cnt, do_write;
    logic              done_pulse, err_pulse;
    logic              remain_one, more_flag;
    logic [ADDR_W-1:0] cur_addr;
    logic [BANK_W-1:0] cur_bank;

    cfgp_frame_fsm #(
        .PREAMBLE_LEN (PREAMBLE_LEN),
        .SYNC_BYTE    (SYNC_BYTE),
        .CTRL_BYTE    (CTRL_BYTE),
        .END_BYTE     (END_BYTE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .full_mode  (full_mode),
        .my_id      (my_id),
        .remain_one (remain_one),
        .more_flag  (more_flag),
        .ld_hdr     (ld_hdr),
        .ld_bank    (ld_bank),
        .ld_cnt     (ld_cnt),
        .do_write   (do_write),
        .done_pulse (done_pulse),
        .err_pulse  (err_pulse)
    );

    cfgp_block_ctr #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_blk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_hdr     (ld_hdr),
        .ld_bank    (ld_bank),
        .ld_cnt     (ld_cnt),
        .do_write   (do_write),
        .hdr_addr   (byte_in[ADDR_W-1:0]),
        .hdr_more   (byte_in[MORE_BIT]),
        .bank_sel   (byte_in[BANK_W-1:0]),
        .count_in   (byte_in),
        .cur_addr   (cur_addr),
        .cur_bank   (cur_bank),
        .more_flag  (more_flag),
        .remain_one (remain_one)
    );

    cfgp_write_port #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_wp (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_write   (do_write),
        .done_pulse (done_pulse),
        .err_pulse  (err_pulse),
        .cur_addr   (cur_addr),
        .cur_bank   (cur_bank),
        .data_in    (byte_in),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );

endmodule

// File: tb/cfg_stream_parser_bench.sv
module cfg_stream_parser_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       byte_valid;
    logic [7:0] byte_in;
    logic       full_mode;
    logic [7:0] my_id;
    logic       wr_en;
    logic [1:0] wr_bank;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic       frame_done;
    logic       frame_err;

    always #2 clk = ~clk;

    cfg_stream_parser u_cfg_stream_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .full_mode  (full_mode),
        .my_id      (my_id),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );

    typedef struct packed {
        logic [1:0] bank;
        logic [4:0] addr;
        logic [7:0] data;
    } exp_t;

    exp_t  q[$];
    exp_t  e;
    int    checks = 0;
    int    errors = 0;
    int    done_seen = 0;
    int    err_seen = 0;
    int    overlap = 0;
    int    gap = 0;
    string cur_req = "R7";

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Driver: one byte per call, held for one clock edge.
    task automatic send(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_in    = 8'h00;
        repeat (gap) @(negedge clk);
    endtask

    // Sends a whole block and queues the writes it should produce.
    task automatic wblk(input logic [7:0] hdr, input logic [7:0] bnk, input int n,
                        input logic [7:0] base, input bit exp_on, input logic [7:0] endm);
        send(hdr);
        send(bnk);
        send(8'(n));
        for (int i = 0; i < n; i++) begin
            if (exp_on) q.push_back({bnk[1:0], 5'(hdr[4:0] + i), 8'(base + i)});
            send(8'(base + i));
        end
        send(endm);
    endtask

    task automatic close_case(input string rq, input int exp_done, input int exp_err);
        repeat (3) @(negedge clk);
        chk({rq, " writes left unmatched"}, q.size(), 0);
        chk({rq, " frame_done pulses"}, done_seen, exp_done);
        chk({rq, " frame_err pulses"}, err_seen, exp_err);
        q.delete();
        done_seen = 0;
        err_seen  = 0;
    endtask

    // Monitor: compares each write against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones({wr_en, frame_done, frame_err}) > 1) overlap++;
            if (frame_done) done_seen++;
            if (frame_err)  err_seen++;
            if (wr_en) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL %s unexpected write: actual bank=%0d addr=%0d data=%02h expected none",
                             cur_req, wr_bank, wr_addr, wr_data);
                end else begin
                    e = q.pop_front();
                    if (e != {wr_bank, wr_addr, wr_data}) begin
                        errors++;
                        $display("FAIL %s write: actual bank=%0d addr=%0d data=%02h expected bank=%0d addr=%0d data=%02h",
                                 cur_req, wr_bank, wr_addr, wr_data, e.bank, e.addr, e.data);
                    end
                end
            end
        end
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        byte_valid = 1'b0;
        byte_in    = 8'h00;
        full_mode  = 1'b0;
        my_id      = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet outputs after reset
        chk("R1 wr_en after reset", int'(wr_en), 0);
        chk("R1 frame_done after reset", int'(frame_done), 0);
        chk("R1 frame_err after reset", int'(frame_err), 0);

        // R2: garbage while hunting, then a short frame
        cur_req = "R2";
        send(8'h00); send(8'h00); send(8'h11); send(8'h2A); send(8'hC1); send(8'h01);
        send(8'hD5); send(8'h01); send(8'hC1);
        wblk(8'h83, 8'h00, 2, 8'hA0, 1'b1, 8'h2A);
        send(8'h00);
        close_case("R2", 1, 0);

        // R3 / R6 / R10: full-format stream, identity run contains 0xD5, chained blocks
        cur_req   = "R3";
        full_mode = 1'b1;
        send(8'h00); send(8'h00); send(8'h00);
        send(8'hD5); send(8'hD5); send(8'hB7); send(8'h20); send(8'h01);
        send(8'h01); send(8'hC1);
        wblk(8'hCE, 8'h00, 4, 8'h51, 1'b1, 8'h2A);
        wblk(8'hDF, 8'h01, 1, 8'hFF, 1'b1, 8'h2A);
        wblk(8'h91, 8'h02, 3, 8'hF0, 1'b1, 8'h2A);
        send(8'h00);
        close_case("R3 R10 full chain", 1, 0);

        // R3: short stream, ID right after sync
        full_mode = 1'b0;
        send(8'hD5); send(8'h01); send(8'hC1);
        wblk(8'hCB, 8'h00, 1, 8'h40, 1'b1, 8'h2A);
        wblk(8'h8F, 8'h00, 2, 8'hFE, 1'b1, 8'h2A);
        send(8'h00);
        close_case("R3 short", 1, 0);

        // R4: foreign ID dropped, then a valid frame is still found
        cur_req = "R4";
        send(8'hD5); send(8'h07); send(8'hC1);
        wblk(8'hCE, 8'h00, 2, 8'h10, 1'b0, 8'h2A);
        wblk(8'h83, 8'h00, 1, 8'h10, 1'b0, 8'h2A);
        send(8'h00);
        send(8'hD5); send(8'h01); send(8'hC1);
        wblk(8'h82, 8'h01, 1, 8'h33, 1'b1, 8'h2A);
        close_case("R4", 1, 0);

        // R5: bad control byte
        cur_req = "R5";
        send(8'hD5); send(8'h01); send(8'hC3);
        wblk(8'h83, 8'h00, 1, 8'h10, 1'b0, 8'h2A);
        close_case("R5", 0, 1);

        // R9: good block then one with a wrong closing byte
        cur_req = "R9";
        send(8'hD5); send(8'h01); send(8'hC1);
        wblk(8'hC4, 8'h00, 2, 8'h60, 1'b1, 8'h2A);
        wblk(8'h88, 8'h01, 2, 8'h70, 1'b1, 8'h55);
        close_case("R9", 0, 1);

        // R8: zero-length block chained to a one-byte block
        cur_req = "R8";
        send(8'hD5); send(8'h01); send(8'hC1);
        wblk(8'hC5, 8'h01, 0, 8'h00, 1'b1, 8'h2A);
        wblk(8'h86, 8'h01, 1, 8'h77, 1'b1, 8'h2A);
        close_case("R8", 1, 0);

        // R7: address wrap 30,31,0; R6: bank byte 0x07 selects bank 3
        cur_req = "R7 R6";
        send(8'hD5); send(8'h01); send(8'hC1);
        wblk(8'h9E, 8'h00, 3, 8'hC0, 1'b1, 8'h2A);
        send(8'hD5); send(8'h01); send(8'hC1);
        wblk(8'h81, 8'h07, 1, 8'h5A, 1'b1, 8'h2A);
        close_case("R7 R6 wrap and bank", 2, 0);

        // R11: idle gaps between every byte
        cur_req   = "R11";
        gap       = 3;
        full_mode = 1'b1;
        send(8'hD5); send(8'h00); send(8'h00); send(8'h00); send(8'h00);
        send(8'h01); send(8'hC1);
        wblk(8'hCA, 8'h02, 2, 8'h90, 1'b1, 8'h2A);
        wblk(8'h94, 8'h03, 1, 8'h21, 1'b1, 8'h2A);
        gap       = 0;
        full_mode = 1'b0;
        close_case("R11", 1, 0);

        // R1: reset in the middle of a payload
        cur_req = "R1";
        send(8'hD5); send(8'h01); send(8'hC1); send(8'hC2); send(8'h00); send(8'h02);
        q.push_back({2'd0, 5'd2, 8'h44});
        send(8'h44);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wr_en after mid-frame reset", int'(wr_en), 0);
        send(8'h45); send(8'h2A);
        send(8'hD5); send(8'h01); send(8'hC1);
        wblk(8'h80, 8'h00, 1, 8'h99, 1'b1, 8'h2A);
        close_case("R1 mid-frame reset", 1, 0);

        // R12: no cycle carried two output events
        chk("R12 simultaneous events", overlap, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule